// File: doc/BRIEF.md
# Security Violation Register Controller

This block gathers six security violation lines and an ECC-failure line for the zeroizable master key into one register page. Each event is latched into a sticky violation status word, and software acknowledges it by writing ones to the bits it has handled. Each source has its own interrupt enable. The interrupt output is a registered OR of the status bits that are both pending and enabled.

A lock word holds sticky freeze bits. Each one blocks further writes to one configuration register until reset. A command word carries self-clearing triggers: a software violation is latched as source 0, and software fatal and software low-power violations are brought out as one-cycle pulses. The security monitor state code comes in on a port and can be read back in the status word. The monitor state machine, the real-time counters and the low-power domain are outside this block.

Register access is a single-cycle write strobe with byte address and 32-bit data. Read data is a combinational function of the address.

Top module: `secviol_regblock`

## Requirements
- R1: After a synchronous active-low reset, every register word reads 0 (the status word shows only the state port), and `irq`, `fatal_pulse` and `lp_viol_pulse` are 0.
- R2: A violation input `viol_in[i]` that is high at a clock edge sets bit i of the violation status word (offset 0x18). The bit stays set after the input falls.
- R3: Writing 1 to bit i in [5:0], or to bit 27 (the ECC-failure flag, which is set by `ecc_fail_in`), of the violation status word clears that bit. Writing 0 leaves the bit unchanged.
- R4: When a violation input is high in the same cycle as a write-one-to-clear of its bit, the bit remains set.
- R5: `irq` equals the OR over bits [5:0] of (violation status AND interrupt config enables at offset 0x0C), registered once. It therefore changes one cycle after the status or the enables change, and writing 0 to the interrupt config drops it.
- R6: Lock word (offset 0x00) bits 17, 16 and 6 are set by writing 1. Writing 0 does not clear them; only reset clears them.
- R7: While lock bit 17 is set, writes to the interrupt config (0x0C) are ignored. Lock bit 16 does the same for the violation control word (0x10), and lock bit 6 for the control word (0x08).
- R8: Writing 1 to command word (0x04) bit 8 sets violation status bit 0 at the same edge. The command word always reads 0.
- R9: Writing 1 to command bit 9 raises `fatal_pulse` for exactly the one cycle after the write edge.
- R10: Writing 1 to command bit 10 raises `lp_viol_pulse` for exactly the one cycle after the write edge.
- R11: Status word (0x14) bits [11:8] equal the `sm_state` input. Its other bits read 0. The codes are 0 init, 1 hard fail, 3 soft fail, 8 transition, 9 check, 11 non-secure, 13 trusted and 15 secure.
- R12: The interrupt config and violation control words hold bits [5:0] only, and other bits read 0. Addresses 0x1C and above, and addresses not aligned to a word, read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 5 | Byte address of the register word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| viol_in | input | 6 | Violation source lines, active high |
| ecc_fail_in | input | 1 | Master key ECC failure event |
| sm_state | input | 4 | Current security monitor state code |
| irq | output | 1 | Registered violation interrupt |
| fatal_pulse | output | 1 | One-cycle software fatal violation |
| lp_viol_pulse | output | 1 | One-cycle software low-power violation |

## Verification
The hardest case to create is a source event that lands in the same cycle as its own acknowledge. The stimulus drives the violation line and the write-one-to-clear in one cycle and then reads the bit back. The interrupt path is swept over every pair of 6-bit pending pattern and enable mask, and `irq` is sampled one cycle after the enables settle. Locks are tested last. A reset between phases shows that only reset releases them.

// File: rtl/secviol_pkg.sv
// Package: shared register indices, bit positions and types for the
// security violation register controller. Assumes 32-bit register words.
package secviol_pkg;

    localparam int NSRC      = 6;      // violation sources
    localparam int DW        = 32;     // register data width

    // word indices (byte offset / 4)
    localparam int IDX_LOCK  = 0;
    localparam int IDX_CMD   = 1;
    localparam int IDX_CTRL  = 2;
    localparam int IDX_ICFG  = 3;
    localparam int IDX_VCTL  = 4;
    localparam int IDX_STAT  = 5;
    localparam int IDX_VSTAT = 6;
    localparam int NWORDS    = 7;

    // lock word bits
    localparam int LK_ICFG   = 17;
    localparam int LK_VCTL   = 16;
    localparam int LK_CTRL   = 6;

    // command word bits
    localparam int CMD_SV    = 8;
    localparam int CMD_FSV   = 9;
    localparam int CMD_LPSV  = 10;

    // status word state field
    localparam int SM_LSB    = 8;
    localparam int SM_W      = 4;

    // violation status ECC flag
    localparam int ECC_BIT   = 27;

    typedef struct packed {
        logic icfg;
        logic vctl;
        logic ctrl;
    } lock_t;

    typedef enum logic [SM_W-1:0] {
        SM_INIT     = 4'd0,
        SM_HARDFAIL = 4'd1,
        SM_SOFTFAIL = 4'd3,
        SM_TRANS    = 4'd8,
        SM_CHECK    = 4'd9,
        SM_NONSEC   = 4'd11,
        SM_TRUSTED  = 4'd13,
        SM_SECURE   = 4'd15
    } sm_state_e;

endpackage

// File: rtl/secviol_decode.sv
// Address decoder: turns a byte address and write strobe into one write
// strobe per register word. Assumes word-aligned accesses; misaligned or
// out-of-range addresses produce no strobe and no hit.
module secviol_decode #(
    parameter int AW     = 5,
    parameter int NWORDS = 7
) (
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    output logic              hit,
    output logic [NWORDS-1:0] wr_word
);
    localparam int WIW = AW - 2;

    logic [WIW-1:0] widx;
    assign widx = addr[AW-1:2];

    // hit: aligned address inside the register page
    always_comb begin
        hit = (addr[1:0] == 2'b00) && (int'(widx) < NWORDS);
    end

    // one strobe per implemented word
    for (genvar w = 0; w < NWORDS; w++) begin : g_strobe
        assign wr_word[w] = wr_en && hit && (int'(widx) == w);
    end
endmodule

// File: rtl/secviol_lockreg.sv
// Lock word: three sticky freeze bits, set by writing 1, cleared only by
// reset. Assumes the caller hands in the three data bits in lock_t order.
module secviol_lockreg
    import secviol_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we,
    input  lock_t set_bits,
    output lock_t lock_q
);
    // sticky OR of written ones
    always_ff @(posedge clk) begin
        if (!rst_n)  lock_q <= '0;
        else if (we) lock_q <= lock_q | set_bits;
    end
endmodule

// File: rtl/secviol_cfgreg.sv
// Generic lockable configuration register of width W. A write while
// 'locked' is high is dropped. Assumes reset value 0.
module secviol_cfgreg #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic         locked,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // load on an unlocked write
    always_ff @(posedge clk) begin
        if (!rst_n)             q <= '0;
        else if (we && !locked) q <= wdata;
    end
endmodule

// File: rtl/secviol_cmd.sv
// Command word: self-clearing triggers. The software violation request is
// passed through combinationally so status latches it at the write edge;
// the fatal and low-power requests become registered one-cycle pulses.
module secviol_cmd (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic req_sv,
    input  logic req_fsv,
    input  logic req_lpsv,
    output logic sw_viol,
    output logic fatal_q,
    output logic lp_q
);
    // software violation toward status source 0
    always_comb begin
        sw_viol = we && req_sv;
    end

    // pulses: high only for the cycle after a requesting write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fatal_q <= 1'b0;
            lp_q    <= 1'b0;
        end else begin
            fatal_q <= we && req_fsv;
            lp_q    <= we && req_lpsv;
        end
    end
endmodule

// File: rtl/secviol_vstat.sv
// Violation status: NSRC sticky source bits plus an ECC flag. A set and a
// write-one-to-clear in the same cycle leave the bit set.
module secviol_vstat #(
    parameter int NSRC = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_src,
    input  logic            set_ecc,
    input  logic            clr_we,
    input  logic [NSRC-1:0] clr_src,
    input  logic            clr_ecc,
    output logic [NSRC-1:0] src_q,
    output logic            ecc_q
);
    // per-source sticky bit; set has priority over clear
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)                   src_q[i] <= 1'b0;
            else if (set_src[i])          src_q[i] <= 1'b1;
            else if (clr_we && clr_src[i]) src_q[i] <= 1'b0;
        end
    end

    // ECC flag, same policy
    always_ff @(posedge clk) begin
        if (!rst_n)                ecc_q <= 1'b0;
        else if (set_ecc)          ecc_q <= 1'b1;
        else if (clr_we && clr_ecc) ecc_q <= 1'b0;
    end
endmodule

// File: rtl/secviol_regblock.sv
// Top: security violation register page. Latches violation lines into
// sticky status, raises a registered interrupt for enabled sources, holds
// lockable configuration and self-clearing command triggers, and reports
// the externally supplied monitor state. Assumes one access per cycle and
// a combinational read path.
module secviol_regblock
    import secviol_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic [NSRC-1:0]  viol_in,
    input  logic             ecc_fail_in,
    input  logic [SM_W-1:0]  sm_state,
    output logic             irq,
    output logic             fatal_pulse,
    output logic             lp_viol_pulse
);
    localparam int WIW = AW - 2;

    logic              hit;
    logic [NWORDS-1:0] wr_word;
    lock_t             lock_q;
    lock_t             lock_set;
    logic [DW-1:0]     ctrl_q;
    logic [NSRC-1:0]   icfg_q;
    logic [NSRC-1:0]   vctl_q;
    logic [NSRC-1:0]   vstat_q;
    logic              ecc_q;
    logic              sw_viol;
    logic [NSRC-1:0]   set_src;
    logic [WIW-1:0]    widx;

    secviol_decode #(.AW(AW), .NWORDS(NWORDS)) u_decode (
        .wr_en   (wr_en),
        .addr    (addr),
        .hit     (hit),
        .wr_word (wr_word)
    );

    // lock bits gathered from their word positions
    always_comb begin
        lock_set.icfg = wdata[LK_ICFG];
        lock_set.vctl = wdata[LK_VCTL];
        lock_set.ctrl = wdata[LK_CTRL];
    end

    secviol_lockreg u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_word[IDX_LOCK]),
        .set_bits (lock_set),
        .lock_q   (lock_q)
    );

    secviol_cfgreg #(.W(DW)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_word[IDX_CTRL]),
        .locked (lock_q.ctrl),
        .wdata  (wdata),
        .q      (ctrl_q)
    );

    secviol_cfgreg #(.W(NSRC)) u_icfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_word[IDX_ICFG]),
        .locked (lock_q.icfg),
        .wdata  (wdata[NSRC-1:0]),
        .q      (icfg_q)
    );

    secviol_cfgreg #(.W(NSRC)) u_vctl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_word[IDX_VCTL]),
        .locked (lock_q.vctl),
        .wdata  (wdata[NSRC-1:0]),
        .q      (vctl_q)
    );

    secviol_cmd u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_word[IDX_CMD]),
        .req_sv   (wdata[CMD_SV]),
        .req_fsv  (wdata[CMD_FSV]),
        .req_lpsv (wdata[CMD_LPSV]),
        .sw_viol  (sw_viol),
        .fatal_q  (fatal_pulse),
        .lp_q     (lp_viol_pulse)
    );

    // source 0 also takes the software violation
    always_comb begin
        set_src    = viol_in;
        set_src[0] = viol_in[0] | sw_viol;
    end

    secviol_vstat #(.NSRC(NSRC)) u_vstat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_src (set_src),
        .set_ecc (ecc_fail_in),
        .clr_we  (wr_word[IDX_VSTAT]),
        .clr_src (wdata[NSRC-1:0]),
        .clr_ecc (wdata[ECC_BIT]),
        .src_q   (vstat_q),
        .ecc_q   (ecc_q)
    );

    // interrupt: pending AND enabled, registered once
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(vstat_q & icfg_q);
    end

    // read mux over the register words
    assign widx = addr[AW-1:2];
    always_comb begin
        rdata = '0;
        if (hit) begin
            case (int'(widx))
                IDX_LOCK: begin
                    rdata[LK_ICFG] = lock_q.icfg;
                    rdata[LK_VCTL] = lock_q.vctl;
                    rdata[LK_CTRL] = lock_q.ctrl;
                end
                IDX_CTRL:  rdata = ctrl_q;
                IDX_ICFG:  rdata[NSRC-1:0] = icfg_q;
                IDX_VCTL:  rdata[NSRC-1:0] = vctl_q;
                IDX_STAT:  rdata[SM_LSB +: SM_W] = sm_state;
                IDX_VSTAT: begin
                    rdata[NSRC-1:0] = vstat_q;
                    rdata[ECC_BIT]  = ecc_q;
                end
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/secviol_checker.sv
// Checker: temporal properties of the register controller, bound to the
// top. Assumes the default 5-bit address and the package bit positions.
module secviol_checker
    import secviol_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [4:0]      addr,
    input logic [DW-1:0]   wdata,
    input logic [DW-1:0]   rdata,
    input logic [NSRC-1:0] viol_in,
    input logic [NSRC-1:0] vstat,
    input logic [NSRC-1:0] icfg,
    input logic            lock_icfg,
    input logic            lock_vctl,
    input logic [NSRC-1:0] vctl,
    input logic            irq,
    input logic            fatal_pulse
);
    // R2: a line high at an edge leaves its status bit set
    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((($past(viol_in)) & ~vstat) == '0));

    // R5: interrupt tracks pending-and-enabled one cycle later
    assert_irq_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|(vstat & icfg))));

    // R6: lock bits never fall while out of reset
    assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lock_icfg)) |-> lock_icfg);

    // R7: locked interrupt config holds
    assert_locked_icfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lock_icfg)) |-> $stable(icfg));

    // R7: locked violation control holds
    assert_locked_vctl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lock_vctl)) |-> $stable(vctl));

    // R8: the command word reads back zero
    assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'h04) |-> (rdata == '0));

    // R9: a fatal pulse only follows a requesting command write
    assert_fatal_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && fatal_pulse) |->
            $past(wr_en && addr == 5'h04 && wdata[CMD_FSV]));
endmodule

bind secviol_regblock secviol_checker u_secviol_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .viol_in     (viol_in),
    .vstat       (vstat_q),
    .icfg        (icfg_q),
    .lock_icfg   (lock_q.icfg),
    .lock_vctl   (lock_q.vctl),
    .vctl        (vctl_q),
    .irq         (irq),
    .fatal_pulse (fatal_pulse)
);

// File: tb/secviol_regblock_bench.sv
// Bench: sweeps sources, state codes and all enable/pending pairs, with
// expected values computed from the requirements.
module secviol_regblock_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [5:0]  viol_in = '0;
    logic        ecc_fail_in = 1'b0;
    logic [3:0]  sm_state = '0;
    logic        irq, fatal_pulse, lp_viol_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    secviol_regblock u_secviol_regblock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .viol_in(viol_in), .ecc_fail_in(ecc_fail_in),
        .sm_state(sm_state), .irq(irq), .fatal_pulse(fatal_pulse),
        .lp_viol_pulse(lp_viol_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; viol_in = '0; ecc_fail_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [4:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: reset state of every word and output
        for (int a = 0; a < 32; a += 4) rd_check("R1", 5'(a), 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 fatal", {31'b0, fatal_pulse}, 32'h0);
        check("R1 lp", {31'b0, lp_viol_pulse}, 32'h0);

        // R11: every state code lands in bits [11:8]
        for (int s = 0; s < 16; s++) begin
            sm_state = 4'(s);
            rd_check("R11", 5'h14, 32'(s) << 8);
        end
        sm_state = 4'd15;

        // R2/R3: each source latches, survives a zero write, clears on one
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); viol_in = 6'(1 << i);
            @(negedge clk); viol_in = '0;
            rd_check("R2", 5'h18, 32'(1 << i));
            wr(5'h18, 32'h0);
            rd_check("R3 zero write", 5'h18, 32'(1 << i));
            wr(5'h18, 32'(1 << i));
            rd_check("R3 clear", 5'h18, 32'h0);
        end
        // R3: ECC flag
        @(negedge clk); ecc_fail_in = 1'b1;
        @(negedge clk); ecc_fail_in = 1'b0;
        rd_check("R3 ecc set", 5'h18, 32'h0800_0000);
        wr(5'h18, 32'h3F);
        rd_check("R3 ecc kept", 5'h18, 32'h0800_0000);
        wr(5'h18, 32'h0800_0000);
        rd_check("R3 ecc clear", 5'h18, 32'h0);

        // R4: set and clear in one cycle, set wins
        @(negedge clk);
        viol_in = 6'b001000; wr_en = 1'b1; addr = 5'h18; wdata = 32'h8;
        @(negedge clk);
        viol_in = '0; wr_en = 1'b0;
        rd_check("R4", 5'h18, 32'h8);
        wr(5'h18, 32'h8);
        rd_check("R4 cleared later", 5'h18, 32'h0);

        // R5: all pending patterns against all enable masks
        for (int p = 0; p < 64; p++) begin
            for (int c = 0; c < 64; c++) begin
                @(negedge clk); viol_in = 6'(p);
                @(negedge clk); viol_in = '0;
                wr(5'h0C, 32'(c));
                @(negedge clk);
                check("R5 sweep", {31'b0, irq}, {31'b0, ((p & c) != 0)});
                wr(5'h18, 32'h3F);
            end
        end
        // R5: zeroing the enables drops the interrupt
        @(negedge clk); viol_in = 6'h3F;
        @(negedge clk); viol_in = '0;
        wr(5'h0C, 32'h3F);
        @(negedge clk);
        check("R5 on", {31'b0, irq}, 32'h1);
        wr(5'h0C, 32'h0);
        @(negedge clk);
        check("R5 off", {31'b0, irq}, 32'h0);
        wr(5'h18, 32'h3F);

        // R12: reserved bits, unmapped and misaligned addresses
        wr(5'h0C, 32'hFFFF_FFFF);
        rd_check("R12 icfg width", 5'h0C, 32'h3F);
        wr(5'h10, 32'hFFFF_FFC5);
        rd_check("R12 vctl width", 5'h10, 32'h05);
        wr(5'h1C, 32'hFFFF_FFFF);
        rd_check("R12 unmapped", 5'h1C, 32'h0);
        wr(5'h0D, 32'h0);
        rd_check("R12 misaligned read", 5'h0D, 32'h0);
        rd_check("R12 misaligned write", 5'h0C, 32'h3F);

        // R8: software violation sets source 0, command reads 0
        wr(5'h04, 32'h100);
        rd_check("R8 status", 5'h18, 32'h1);
        rd_check("R8 readback", 5'h04, 32'h0);
        wr(5'h18, 32'h1);

        // R9: fatal pulse one cycle
        wr(5'h04, 32'h200);
        check("R9 high", {31'b0, fatal_pulse}, 32'h1);
        check("R9 no lp", {31'b0, lp_viol_pulse}, 32'h0);
        @(negedge clk);
        check("R9 low", {31'b0, fatal_pulse}, 32'h0);

        // R10: low-power pulse one cycle
        wr(5'h04, 32'h400);
        check("R10 high", {31'b0, lp_viol_pulse}, 32'h1);
        check("R10 no fatal", {31'b0, fatal_pulse}, 32'h0);
        @(negedge clk);
        check("R10 low", {31'b0, lp_viol_pulse}, 32'h0);

        // R6/R7: locks freeze their registers and stay set
        wr(5'h08, 32'hA5A5_5A5A);
        wr(5'h00, 32'h40);
        wr(5'h08, 32'h1234_5678);
        rd_check("R7 ctrl locked", 5'h08, 32'hA5A5_5A5A);
        wr(5'h0C, 32'h0);
        rd_check("R7 icfg still open", 5'h0C, 32'h0);
        wr(5'h0C, 32'h15);
        wr(5'h00, 32'h0002_0000);
        wr(5'h0C, 32'h2A);
        rd_check("R7 icfg locked", 5'h0C, 32'h15);
        wr(5'h10, 32'h33);
        wr(5'h00, 32'h0001_0000);
        wr(5'h10, 32'h0C);
        rd_check("R7 vctl locked", 5'h10, 32'h33);
        wr(5'h00, 32'h0);
        rd_check("R6 sticky", 5'h00, 32'h0003_0040);
        do_reset();
        rd_check("R6 reset clears", 5'h00, 32'h0);
        wr(5'h08, 32'h1234_5678);
        rd_check("R6 ctrl writable after reset", 5'h08, 32'h1234_5678);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule